// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the interval between chosen transitions of a fan speed-sense pulse train. It counts ticks of a prescaled clock and latches the result as a 20-bit period value. The sense input is resynchronised, optionally filtered, and edge-detected. A control FSM then arms on the first selected edge and captures the tick count on each later one. If no edge arrives before the counter fills, the result is forced to all ones, which marks a stalled or far too slow fan. Every latched value is also compared against a programmable limit. The compare direction is selectable, and a trip can raise a sticky interrupt status.

The prescaler divides the clock by 4^k for a 4-bit code k from 0 to 11. Codes above 11 behave as 11. Configuration is static: it is changed while `meas_en` is low. For self-test, a loop-back select can feed the channel's own PWM output into the sense path instead of the pin.

The control FSM has four states:
- IDLE: disabled. It moves to ARM when `meas_en` rises.
- ARM: waits for the first selected edge, then moves to COUNT.
- COUNT: counts ticks. A selected edge captures the count and stays in COUNT. A counter fill captures all ones and moves to STALL.
- STALL: waits for an edge, then returns to COUNT without capturing.

Dropping `meas_en` returns every state to IDLE.

Top module: `fan_period_meter`

## Requirements
- R1: After reset, meas_val is 0, and val_upd, full_meas, irq_sts and irq are all 0.
- R2: Divide code k yields one counting tick every 4^k clocks. A captured value is the number of ticks between two selected edges, so a period of P clocks with P a multiple of 4^k reads P/4^k.
- R3: edge_sel 00 times falling-to-falling edges, 01 rising-to-rising, 10 any edge to the next edge. Code 11 selects no edge, so nothing is ever captured.
- R4: If the count reaches 2^W-1 ticks (W = 20 by default) without a selected edge, meas_val becomes all ones with full_meas 0 and val_upd set. Timing resumes normally from the next selected edge.
- R5: full_meas is 1 after the capture of a complete period. The first selected edge after enabling only arms the measurement.
- R6: val_upd is set on each capture and cleared by a one-cycle val_rd strobe. A capture in the same cycle as the strobe leaves it set.
- R7: With limit_inv 0 a capture trips when the value is above limit; with limit_inv 1 when it is below limit. A trip sets irq_sts only if irq_en is 1, and irq is irq_sts AND irq_en.
- R8: An irq_clr strobe clears irq_sts. A trip in the same cycle as the strobe leaves it set.
- R9: raw_lvl shows the selected sense input two clocks after it changes.
- R10: deb_sel 0 passes the synchronised level straight through. deb_sel d > 0 changes deb_lvl only after the new level has held for 2^(d+1) consecutive ticks, so shorter pulses are ignored.
- R11: loop_en 1 takes the sense signal from pwm_loop instead of tach_in.
- R12: While meas_en is 0 the FSM stays in IDLE, no capture occurs, and full_meas is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | 1 | Fan speed-sense pin |
| pwm_loop | input | 1 | Channel PWM output, used for loop-back |
| loop_en | input | 1 | Select pwm_loop as the sense source |
| meas_en | input | 1 | Measurement enable |
| edge_sel | input | 2 | Edge mode: 00 fall, 01 rise, 10 both, 11 none |
| deb_sel | input | 2 | Debounce setting |
| div_code | input | 4 | Prescale code k, divide by 4^k |
| limit | input | CNT_W | Compare threshold |
| limit_inv | input | 1 | Invert compare direction |
| irq_en | input | 1 | Interrupt enable |
| val_rd | input | 1 | Read strobe, clears val_upd |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_sts |
| meas_val | output | CNT_W | Latched period in ticks |
| val_upd | output | 1 | New value latched since last read |
| full_meas | output | 1 | Latched value is a complete period |
| raw_lvl | output | 1 | Synchronised sense level |
| deb_lvl | output | 1 | Filtered sense level |
| irq_sts | output | 1 | Sticky threshold status |
| irq | output | 1 | Interrupt request |

## Verification
A capture can land in the same cycle as a val_rd strobe, or in the same cycle as an irq_clr strobe.

To provoke both collisions, the bench first runs a steady period of known length. It then observes a capture and clears both flags. It raises both strobes again for exactly the one clock edge, one full period later, on which the next capture lands.

The collision is judged correct when val_upd and irq_sts are both still high after that edge. The separate clear one period earlier must have dropped them.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_COUNT,
        ST_STALL
    } per_state_e;

endpackage

// File: rtl/fpm_tick_gen.sv
module fpm_tick_gen #(
    parameter int MAX_CODE = 11,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              tick
);
    localparam int PRE_W = 2 * MAX_CODE;
    localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] code_c;
    logic [PRE_W-1:0]  lim_m1;
    logic [PRE_W-1:0]  pre_cnt;

    always_comb begin
        code_c = (div_code > CODE_TOP) ? CODE_TOP : div_code;
        lim_m1 = (PRE_W'(1) << {code_c, 1'b0}) - PRE_W'(1);
        tick   = (pre_cnt >= lim_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (tick) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // R2: with a nonzero code, two ticks never fall on adjacent clocks
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code_c != '0) |=> (!tick || code_c == '0));

endmodule

// File: rtl/fpm_input_filter.sv
module fpm_input_filter #(
    parameter int DEB_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       tick,
    input  logic [1:0] deb_sel,
    output logic       raw_o,
    output logic       deb_o
);
    logic             s1_q, s2_q, deb_q;
    logic [DEB_W-1:0] dcnt;
    logic [DEB_W-1:0] need_m1;

    always_comb need_m1 = DEB_W'((32'd2 << deb_sel) - 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            deb_q <= 1'b0;
            dcnt  <= '0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            if (deb_sel == 2'd0) begin
                deb_q <= s2_q;
                dcnt  <= '0;
            end else if (s2_q == deb_q) begin
                dcnt <= '0;
            end else if (tick) begin
                if (dcnt == need_m1) begin
                    deb_q <= s2_q;
                    dcnt  <= '0;
                end else begin
                    dcnt <= dcnt + DEB_W'(1);
                end
            end
        end
    end

    assign raw_o = s2_q;
    assign deb_o = deb_q;

    // R10: when filtering is on, the filtered level moves only on a tick
    p_deb_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_sel != 2'd0 && !tick) |=> $stable(deb_q));

endmodule

// File: rtl/fpm_period_fsm.sv
module fpm_period_fsm
    import fpm_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             hit,
    output logic             cap_vld,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_full,
    output per_state_e       st_o
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST = ALL1 - CNT_W'(1);

    per_state_e       st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             fill;

    assign fill = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (en) nxt = ST_ARM;
            ST_ARM:   if (!en) nxt = ST_IDLE; else if (hit) nxt = ST_COUNT;
            ST_COUNT: if (!en) nxt = ST_IDLE; else if (!hit && fill) nxt = ST_STALL;
            ST_STALL: if (!en) nxt = ST_IDLE; else if (hit) nxt = ST_COUNT;
        endcase
    end

    always_comb begin
        cap_vld  = 1'b0;
        cap_val  = ALL1;
        cap_full = 1'b0;
        unique case (st)
            ST_COUNT: begin
                cap_vld  = en && (hit || fill);
                cap_val  = hit ? cnt : ALL1;
                cap_full = hit;
            end
            ST_IDLE, ST_ARM, ST_STALL: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (st == ST_IDLE || !en)       cnt <= '0;
        else if (hit)                        cnt <= tick ? CNT_W'(1) : '0;
        else if (st == ST_COUNT && tick)     cnt <= cnt + CNT_W'(1);
    end

    assign st_o = st;

    // R12: dropping the enable always lands in IDLE
    p_idle_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_IDLE));

    // R4: a stalled measurement waits for an edge
    p_stall_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL && en && !hit) |=> (st == ST_STALL));

endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
    import fpm_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int MAX_CODE = 11,
    parameter int DEB_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic             pwm_loop,
    input  logic             loop_en,
    input  logic             meas_en,
    input  logic [1:0]       edge_sel,
    input  logic [1:0]       deb_sel,
    input  logic [3:0]       div_code,
    input  logic [CNT_W-1:0] limit,
    input  logic             limit_inv,
    input  logic             irq_en,
    input  logic             val_rd,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] meas_val,
    output logic             val_upd,
    output logic             full_meas,
    output logic             raw_lvl,
    output logic             deb_lvl,
    output logic             irq_sts,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    logic             tick, pin_sel, prev_q, hit, trip;
    logic             cap_vld, cap_full;
    logic [CNT_W-1:0] cap_val;
    per_state_e       fsm_st;
    edge_mode_e       mode;

    assign pin_sel = loop_en ? pwm_loop : tach_in;
    assign mode    = edge_mode_e'(edge_sel);

    fpm_tick_gen #(.MAX_CODE(MAX_CODE), .CODE_W(4)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_code(div_code), .tick(tick));

    fpm_input_filter #(.DEB_W(DEB_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .pin(pin_sel), .tick(tick),
        .deb_sel(deb_sel), .raw_o(raw_lvl), .deb_o(deb_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= deb_lvl;
    end

    always_comb begin
        unique case (mode)
            EDGE_FALL: hit = prev_q & ~deb_lvl;
            EDGE_RISE: hit = ~prev_q & deb_lvl;
            EDGE_BOTH: hit = prev_q ^ deb_lvl;
            EDGE_NONE: hit = 1'b0;
        endcase
    end

    fpm_period_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(meas_en), .tick(tick), .hit(hit),
        .cap_vld(cap_vld), .cap_val(cap_val), .cap_full(cap_full), .st_o(fsm_st));

    assign trip = limit_inv ? (cap_val < limit) : (cap_val > limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_val  <= '0;
            full_meas <= 1'b0;
            val_upd   <= 1'b0;
            irq_sts   <= 1'b0;
        end else begin
            if (cap_vld) begin
                meas_val  <= cap_val;
                full_meas <= cap_full;
            end else if (!meas_en) begin
                full_meas <= 1'b0;
            end
            if (cap_vld)     val_upd <= 1'b1;
            else if (val_rd) val_upd <= 1'b0;
            if (cap_vld && irq_en && trip) irq_sts <= 1'b1;
            else if (irq_clr)              irq_sts <= 1'b0;
        end
    end

    assign irq = irq_sts & irq_en;

    // R4: an all-ones result never claims a complete period
    p_sat_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_val == ALL1) |-> !full_meas);

    // R6: a fresh update only comes out of the counting state
    p_upd_from_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(val_upd) |-> ($past(fsm_st) == ST_COUNT));

    // R7: status rises only while the interrupt was enabled
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sts) |-> $past(irq_en));

    // R8: a clear with no concurrent trip drops the status
    p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cap_vld) |=> !irq_sts);

endmodule

// File: tb/fan_period_meter_test.sv
module fan_period_meter_test;
    localparam int W = 10;
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic man_lvl = 1'b0, gen_on = 1'b1, gen_to_loop = 1'b0, gen_lvl = 1'b1;
    int   gen_hi = 10, gen_lo = 10, ph = 0;
    logic loop_en = 0, meas_en = 0, limit_inv = 0, irq_en = 0, val_rd = 0, irq_clr = 0;
    logic [1:0] edge_sel = 0, deb_sel = 0;
    logic [3:0] div_code = 0;
    logic [W-1:0] limit = '1;
    logic tach_in, pwm_loop;
    logic [W-1:0] meas_val;
    logic val_upd, full_meas, raw_lvl, deb_lvl, irq_sts, irq;
    int n_run = 0, n_fail = 0;

    assign tach_in  = (gen_on && !gen_to_loop) ? gen_lvl : man_lvl;
    assign pwm_loop = (gen_on && gen_to_loop) ? gen_lvl : 1'b0;

    fan_period_meter #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .pwm_loop(pwm_loop),
        .loop_en(loop_en), .meas_en(meas_en), .edge_sel(edge_sel), .deb_sel(deb_sel),
        .div_code(div_code), .limit(limit), .limit_inv(limit_inv), .irq_en(irq_en),
        .val_rd(val_rd), .irq_clr(irq_clr), .meas_val(meas_val), .val_upd(val_upd),
        .full_meas(full_meas), .raw_lvl(raw_lvl), .deb_lvl(deb_lvl),
        .irq_sts(irq_sts), .irq(irq));

    always @(negedge clk) begin
        if (!gen_on) begin
            ph <= 0;
            gen_lvl <= 1'b1;
        end else if (ph >= (gen_lvl ? gen_hi : gen_lo) - 1) begin
            ph <= 0;
            gen_lvl <= ~gen_lvl;
        end else begin
            ph <= ph + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_val(input int hi, input int lo, input int k, input int mode);
        int t = 1 << (2 * k);
        return (mode == 2) ? hi / t : (hi + lo) / t;
    endfunction

    task automatic setup(input int mode, input int d, input int k, input int hi, input int lo);
        meas_en  = 1'b0;
        edge_sel = 2'(mode);
        deb_sel  = 2'(d);
        div_code = 4'(k);
        gen_hi   = hi;
        gen_lo   = lo;
        repeat (3) @(negedge clk);
        meas_en  = 1'b1;
    endtask

    task automatic get_cap(output int v, output int f);
        int guard = 0;
        val_rd = 1'b1;
        @(negedge clk);
        val_rd = 1'b0;
        while (!val_upd && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        v = int'(meas_val);
        f = int'(full_meas);
    endtask

    task automatic settle(output int v, output int f);
        repeat (3) get_cap(v, f);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, f, c1, c2, unused;
        unused = $urandom(32'd51423);
        repeat (5) @(negedge clk);
        chk("R1 meas_val", int'(meas_val), 0);
        chk("R1 val_upd", int'(val_upd), 0);
        chk("R1 full_meas", int'(full_meas), 0);
        chk("R1 irq_sts", int'(irq_sts), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1'b1;

        // R3 / R5: falling, rising and both-edge timing with unequal duty
        setup(0, 0, 0, 8, 12); settle(v, f);
        chk("R3 falling period", v, 20);
        chk("R5 full after period", f, 1);
        setup(1, 0, 0, 8, 12); settle(v, f);
        chk("R3 rising period", v, 20);
        setup(2, 0, 0, 8, 12); settle(c1, f); get_cap(c2, f);
        chk("R3 both edges sum", c1 + c2, 20);
        chk("R3 both edges alternate", int'(c1 != c2), 1);

        // R2: divide by four
        setup(0, 0, 1, 20, 20); settle(v, f);
        chk("R2 div code 1", v, 10);

        // R6 / R7 / R8: same-cycle capture versus clear strobes
        limit = 5; limit_inv = 0; irq_en = 1;
        setup(0, 0, 0, 10, 10); settle(v, f);
        chk("R7 trip above limit", int'(irq_sts), 1);
        chk("R7 irq out", int'(irq), 1);
        val_rd = 1; irq_clr = 1;
        @(negedge clk);
        val_rd = 0; irq_clr = 0;
        chk("R6 read clears", int'(val_upd), 0);
        chk("R8 clear works", int'(irq_sts), 0);
        repeat (18) @(negedge clk);
        val_rd = 1; irq_clr = 1;
        @(negedge clk);
        val_rd = 0; irq_clr = 0;
        chk("R6 capture beats read", int'(val_upd), 1);
        chk("R8 trip beats clear", int'(irq_sts), 1);

        // R7: inverted direction and enable gating
        limit_inv = 1;
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        get_cap(v, f); get_cap(v, f);
        chk("R7 inverted no trip", int'(irq_sts), 0);
        limit = 30; get_cap(v, f); get_cap(v, f);
        chk("R7 inverted trip below", int'(irq_sts), 1);
        irq_en = 0;
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        get_cap(v, f); get_cap(v, f);
        chk("R7 disabled no status", int'(irq_sts), 0);
        chk("R7 disabled no irq", int'(irq), 0);
        limit = '1; limit_inv = 0;

        // R3: reserved mode captures nothing
        setup(3, 0, 0, 10, 10);
        val_rd = 1; @(negedge clk); val_rd = 0;
        repeat (200) @(negedge clk);
        chk("R3 mode 11 no capture", int'(val_upd), 0);

        // R12: disabled
        setup(0, 0, 0, 10, 10); settle(v, f);
        meas_en = 0;
        val_rd = 1; @(negedge clk); val_rd = 0;
        repeat (200) @(negedge clk);
        chk("R12 no capture when off", int'(val_upd), 0);
        chk("R12 full cleared", int'(full_meas), 0);

        // R4: saturation and recovery
        setup(0, 0, 0, 10, 10); settle(v, f);
        gen_on = 0; man_lvl = 0;
        v = 0;
        for (int i = 0; i < 4 && v != int'(ALL1); i++) get_cap(v, f);
        chk("R4 saturated value", v, int'(ALL1));
        chk("R4 saturated not full", f, 0);
        gen_on = 1; settle(v, f);
        chk("R4 resumes", v, 20);

        // R9 / R10: synchroniser and glitch filter
        gen_on = 0; man_lvl = 0; deb_sel = 2;
        repeat (30) @(negedge clk);
        man_lvl = 1;
        @(negedge clk); @(negedge clk);
        chk("R9 raw after two clocks", int'(raw_lvl), 1);
        @(negedge clk); man_lvl = 0;
        repeat (20) @(negedge clk);
        chk("R10 glitch rejected", int'(deb_lvl), 0);
        man_lvl = 1;
        repeat (6) @(negedge clk);
        chk("R10 not yet stable", int'(deb_lvl), 0);
        repeat (10) @(negedge clk);
        chk("R10 stable accepted", int'(deb_lvl), 1);
        deb_sel = 0; man_lvl = 0;
        repeat (4) @(negedge clk);
        chk("R10 bypass follows", int'(deb_lvl), 0);

        // R11: loop-back source
        gen_on = 1; gen_to_loop = 1; loop_en = 0;
        setup(0, 0, 0, 15, 15);
        val_rd = 1; @(negedge clk); val_rd = 0;
        repeat (300) @(negedge clk);
        chk("R11 pin idle without loopback", int'(val_upd), 0);
        loop_en = 1;
        setup(0, 0, 0, 15, 15); settle(v, f);
        chk("R11 loopback period", v, 30);
        loop_en = 0; gen_to_loop = 0;

        // R2 / R3 / R10: random configurations
        for (int n = 0; n < 6; n++) begin
            int k, mode, d, h;
            k    = $urandom_range(0, 2);
            mode = $urandom_range(0, 2);
            d    = $urandom_range(0, 3);
            h    = $urandom_range(20, 40) << (2 * k);
            setup(mode, d, k, h, h); settle(v, f);
            chk("R2 random period", v, exp_val(h, h, k, mode));
            chk("R5 random full", f, 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule